// File: doc/BRIEF.md
# Idle Insert/Delete Elastic Buffer

This block is a dual-clock slip buffer for a four-lane, 10 Gb/s style media-independent stream. Each stored word is 72 bits wide and carries two consecutive beats. Each beat has four lanes, and each lane is a 9-bit slot made of one control flag and an 8-bit code. The buffer moves words from a write clock domain into a read clock domain. It absorbs a small frequency offset between the two clocks by changing the stream itself, and only in the gap between frames. Outside a frame, an idle word that arrives while the buffer is highly filled is dropped. Outside a frame, a read while the buffer is lightly filled returns a freshly made idle word and consumes nothing.

Reading is held off after reset until the fill first reaches the low watermark. Pointers cross between the domains in Gray code. Each side computes its own fill level, so the write-side flags and the read-side flags are produced in their own clock domains. Misuse is caught by two sticky error flags, one per side: a write into a full buffer, or a read from an empty buffer while no idle can be supplied.

Top module: `slip_buffer`

## Requirements
- R1: Word layout: slot k (k = 0..7) occupies bits [9k+8:9k], with bit 9k+8 as the control flag and bits [9k+7:9k] as the code. Slots 0..3 are lanes 0..3 of the first beat and slots 4..7 are lanes 0..3 of the second beat. Every stored word is delivered on `rd_data` unaltered and in write order, and the buffer holds up to 256 words.
- R2: `wr_full` is 1 exactly when the write-side fill equals 256. `wr_part_full` is 1 when that fill is at least PF_MARK (default 192).
- R3: `rd_empty` is 1 when the read-side fill is 0. `rd_part_empty` is 1 when that fill is below PE_MARK (default 64). Whenever `rd_empty` is 1, `rd_part_empty` is also 1.
- R4: After reset, `rd_en` produces no output (`rd_valid` stays 0) and raises no error until the read-side fill has first reached PE_MARK.
- R5: A word is idle when all eight slots equal 0x107 (control 1, code 0x07). An idle word written outside a frame while `wr_part_full` is 1 is discarded and not stored.
- R6: Idle words written inside a frame are stored, even when `wr_part_full` is 1.
- R7: Once reading has started, a `rd_en` issued outside a frame while the read-side fill is below PE_MARK yields one all-idle word on `rd_data` with `rd_valid` 1 and consumes nothing. This insertion continues on every such read until the fill reaches PF_MARK.
- R8: A frame opens when slot 0 or slot 4 holds 0x1FB (start). It closes when any slot holds 0x1FD (terminate); terminate takes precedence if a word holds both. No idle word is inserted on the read side while a frame is open.
- R9: A write of a non-discarded word while `wr_full` is 1 is ignored and sets `wr_err`, which stays set until reset.
- R10: A `rd_en` on an empty buffer when no insertion applies keeps `rd_valid` at 0 and sets `rd_err`, which stays set until reset.
- R11: After reset, `rd_empty` and `rd_part_empty` are 1, while `wr_full`, `wr_part_full`, `rd_valid`, `wr_err` and `rd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain asynchronous reset, active low |
| wr_valid | input | 1 | Offers `wr_data` for storage this cycle |
| wr_data | input | 72 | Two-beat, four-lane word to store |
| wr_full | output | 1 | Write-side fill equals capacity |
| wr_part_full | output | 1 | Write-side fill at or above PF_MARK |
| wr_err | output | 1 | Sticky: write attempted while full |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain asynchronous reset, active low |
| rd_en | input | 1 | Requests one output word |
| rd_valid | output | 1 | `rd_data` holds a new word this cycle |
| rd_data | output | 72 | Delivered or inserted word |
| rd_empty | output | 1 | Read-side fill is zero |
| rd_part_empty | output | 1 | Read-side fill below PE_MARK |
| rd_err | output | 1 | Sticky: read attempted while empty with no insertion |

## Verification
Faults in the frame tracking are visible at the ports within one read cycle. If the read side loses track of a frame, an idle word appears inside payload or the sticky read error fires where insertion was due. If the write side loses track, the wrong words are dropped, and the error shows up when the read-back stream is compared word for word with the bench's own model of what should have been kept. Pointer or Gray-crossing errors show a few cycles after the synchroniser delay, as fill flags that disagree with the number of words written and read. They also show as a duplicated, missing or reordered word in the drained stream. Watermark errors move the cycle at which reading starts and at which full or part-full rises, and the bench checks those at fixed fill counts.

// File: rtl/elbuf_pkg.sv
package elbuf_pkg;
   localparam int SLOT_W  = 9;
   localparam int SLOTS   = 8;
   localparam int WORD_W  = SLOT_W * SLOTS;
   localparam logic [SLOT_W-1:0] CODE_IDLE  = 9'h107;
   localparam logic [SLOT_W-1:0] CODE_START = 9'h1FB;
   localparam logic [SLOT_W-1:0] CODE_TERM  = 9'h1FD;

   typedef logic [WORD_W-1:0] word_t;

   localparam word_t IDLE_WORD = {SLOTS{CODE_IDLE}};

   function automatic logic is_idle(input word_t w);
      logic r;
      r = 1'b1;
      for (int k = 0; k < SLOTS; k++)
         if (w[k*SLOT_W +: SLOT_W] != CODE_IDLE) r = 1'b0;
      return r;
   endfunction

   function automatic logic has_start(input word_t w);
      return (w[0 +: SLOT_W] == CODE_START) || (w[4*SLOT_W +: SLOT_W] == CODE_START);
   endfunction

   function automatic logic has_term(input word_t w);
      logic r;
      r = 1'b0;
      for (int k = 0; k < SLOTS; k++)
         if (w[k*SLOT_W +: SLOT_W] == CODE_TERM) r = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/elbuf_sync.sv
module elbuf_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/elbuf_mem.sv
module elbuf_mem #(
   parameter int AW = 8,
   parameter int DW = 72
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge wclk)
      if (we) cells[waddr] <= wdata;

   assign rdata = cells[raddr];
endmodule

// File: rtl/elbuf_wr.sv
module elbuf_wr
   import elbuf_pkg::*;
#(
   parameter int AW      = 8,
   parameter int PF_MARK = 192
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  word_t         data,
   input  logic [AW:0]   rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic          full,
   output logic          pfull,
   output logic          err
);
   localparam logic [AW:0] DEPTH_L = {1'b1, {AW{1'b0}}};
   localparam logic [AW:0] PF_L    = (AW+1)'(PF_MARK);

   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW-1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0] wbin, wbin_nxt, rbin_s, wfill;
   logic        in_pkt, drop;

   assign rbin_s   = g2b(rgray_s);
   assign wfill    = wbin - rbin_s;
   assign full     = (wfill == DEPTH_L);
   assign pfull    = (wfill >= PF_L);
   assign drop     = valid && is_idle(data) && !in_pkt && pfull;
   assign we       = valid && !drop && !full;
   assign wbin_nxt = wbin + {{AW{1'b0}}, we};
   assign waddr    = wbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         in_pkt <= 1'b0;
         err    <= 1'b0;
      end else begin
         wbin  <= wbin_nxt;
         wgray <= wbin_nxt ^ (wbin_nxt >> 1);
         if (we) begin
            if (has_term(data))       in_pkt <= 1'b0;
            else if (has_start(data)) in_pkt <= 1'b1;
         end
         if (valid && !drop && full) err <= 1'b1;
      end
   end

   // R5
   idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && is_idle(data) && !in_pkt && pfull) |=> $stable(wbin));
   // R9
   full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && full) |=> ($stable(wbin) && (err || $past(drop))));
   // R2
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wfill <= DEPTH_L);
endmodule

// File: rtl/elbuf_rd.sv
module elbuf_rd
   import elbuf_pkg::*;
#(
   parameter int AW      = 8,
   parameter int PE_MARK = 64,
   parameter int PF_MARK = 192
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  word_t         mem_q,
   input  logic [AW:0]   wgray_s,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic          rd_valid,
   output word_t         rd_data,
   output logic          empty,
   output logic          pempty,
   output logic          err
);
   localparam logic [AW:0] PE_L = (AW+1)'(PE_MARK);
   localparam logic [AW:0] PF_L = (AW+1)'(PF_MARK);

   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW-1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0] rbin, rbin_nxt, wbin_s, rfill;
   logic        started, ins_act, in_pkt, do_ins, do_pop;

   assign wbin_s   = g2b(wgray_s);
   assign rfill    = wbin_s - rbin;
   assign empty    = (rfill == '0);
   assign pempty   = (rfill < PE_L);
   assign do_ins   = rd_en && started && !in_pkt && (ins_act || pempty);
   assign do_pop   = rd_en && started && !do_ins && !empty;
   assign rbin_nxt = rbin + {{AW{1'b0}}, do_pop};
   assign raddr    = rbin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         started  <= 1'b0;
         ins_act  <= 1'b0;
         in_pkt   <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         err      <= 1'b0;
      end else begin
         rbin     <= rbin_nxt;
         rgray    <= rbin_nxt ^ (rbin_nxt >> 1);
         rd_valid <= do_ins || do_pop;
         if (!started && !pempty) started <= 1'b1;
         if (started && !in_pkt && pempty) ins_act <= 1'b1;
         else if (rfill >= PF_L)           ins_act <= 1'b0;
         if (do_ins) begin
            rd_data <= IDLE_WORD;
         end else if (do_pop) begin
            rd_data <= mem_q;
            if (has_term(mem_q))       in_pkt <= 1'b0;
            else if (has_start(mem_q)) in_pkt <= 1'b1;
         end
         if (rd_en && started && !do_ins && empty) err <= 1'b1;
      end
   end

   // R4
   read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> started);
   // R7
   insert_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (rbin == $past(rbin))) |-> (is_idle(rd_data) && !in_pkt));
   // R10
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && started && empty && in_pkt) |=> (!rd_valid && err));
   // R3
   flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> pempty);
endmodule

// File: rtl/slip_buffer.sv
module slip_buffer
   import elbuf_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PE_MARK     = 64,
   parameter int PF_MARK     = 192
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   output logic              wr_full,
   output logic              wr_part_full,
   output logic              wr_err,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_empty,
   output logic              rd_part_empty,
   output logic              rd_err
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = ADDR_W + 1;

   generate
      if (PE_MARK < 1 || PE_MARK >= PF_MARK) begin : g_bad_marks
         $error("slip_buffer: need 1 <= PE_MARK < PF_MARK");
      end
      if (PF_MARK > DEPTH) begin : g_bad_pf
         $error("slip_buffer: PF_MARK exceeds depth");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("slip_buffer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              we;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
   word_t             mem_q;

   elbuf_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
      .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(mem_q));

   elbuf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));

   elbuf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));

   elbuf_wr #(.AW(ADDR_W), .PF_MARK(PF_MARK)) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .valid(wr_valid), .data(wr_data),
      .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
      .full(wr_full), .pfull(wr_part_full), .err(wr_err));

   elbuf_rd #(.AW(ADDR_W), .PE_MARK(PE_MARK), .PF_MARK(PF_MARK)) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .mem_q(mem_q),
      .wgray_s(wgray_s), .raddr(raddr), .rgray(rgray),
      .rd_valid(rd_valid), .rd_data(rd_data), .empty(rd_empty),
      .pempty(rd_part_empty), .err(rd_err));
endmodule

// File: tb/slip_buffer_test.sv
module slip_buffer_test;
   import elbuf_pkg::*;

   logic  wr_clk = 1'b0, rd_clk = 1'b0;
   logic  wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic  wr_valid = 1'b0, rd_en = 1'b0;
   word_t wr_data = '0;
   logic  wr_full, wr_part_full, wr_err, rd_valid, rd_empty, rd_part_empty, rd_err;
   word_t rd_data;

   int total = 0, bad = 0;
   bit done = 0;
   word_t exp_q[$];
   word_t got_q[$];

   always #10   wr_clk = ~wr_clk;
   always #10.5 rd_clk = ~rd_clk;

   slip_buffer uut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_full(wr_full), .wr_part_full(wr_part_full), .wr_err(wr_err),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_empty(rd_empty), .rd_part_empty(rd_part_empty), .rd_err(rd_err));

   always @(negedge rd_clk)
      if (rd_valid) got_q.push_back(rd_data);

   task automatic check(input bit ok, input string req, input word_t act, input word_t exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic word_t mk_data();
      word_t w;
      for (int k = 0; k < SLOTS; k++) w[k*SLOT_W +: SLOT_W] = {1'b0, 8'($urandom)};
      return w;
   endfunction

   function automatic word_t mk_start();
      word_t w = mk_data();
      w[0 +: SLOT_W] = CODE_START;
      return w;
   endfunction

   function automatic word_t mk_term();
      word_t w = mk_data();
      w[5*SLOT_W +: SLOT_W] = CODE_TERM;
      return w;
   endfunction

   function automatic bit idle_ref(input word_t w);
      return w == {SLOTS{9'h107}};
   endfunction

   // drive one write; caller is at a negedge of wr_clk
   task automatic put(input word_t w, input bit keep);
      wr_valid = 1'b1;
      wr_data  = w;
      if (keep) exp_q.push_back(w);
      @(negedge wr_clk);
      wr_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (12) @(negedge wr_clk);
   endtask

   initial begin
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge wr_clk);
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      @(negedge wr_clk);
      // R11 reset state
      check(rd_empty && rd_part_empty && !wr_full && !wr_part_full && !rd_valid && !wr_err && !rd_err,
            "R11", {wr_full, wr_part_full, rd_empty, rd_part_empty, rd_valid, wr_err, rd_err},
            7'b0011000);

      // frame 1 with rd_en asserted before the start watermark: R4
      rd_en = 1'b1;
      put(mk_start(), 1);
      for (int i = 0; i < 20; i++) put(mk_data(), 1);
      put(mk_term(), 1);
      settle();
      rd_en = 1'b0;
      settle();
      check(got_q.size() == 0 && !rd_err, "R4", got_q.size(), 0);
      check(!rd_empty && rd_part_empty, "R3", {rd_empty, rd_part_empty}, 2'b01);

      // cross the start watermark outside a frame
      for (int i = 0; i < 50; i++) put(mk_data(), 1);
      settle();
      check(!rd_part_empty, "R3", rd_part_empty, 0);
      check(!wr_part_full, "R2", wr_part_full, 0);

      // idles outside a frame up to PF_MARK are stored
      for (int i = 0; i < 120; i++) put({SLOTS{CODE_IDLE}}, 1);
      @(negedge wr_clk);
      check(wr_part_full && !wr_full, "R2", {wr_full, wr_part_full}, 2'b01);
      // R5: further idles outside a frame are dropped
      for (int i = 0; i < 10; i++) put({SLOTS{CODE_IDLE}}, 0);
      // R6: idles inside a frame are kept
      put(mk_start(), 1);
      for (int i = 0; i < 3; i++) put({SLOTS{CODE_IDLE}}, 1);
      for (int i = 0; i < 60; i++) put(mk_data(), 1);
      @(negedge wr_clk);
      check(wr_full, "R2", wr_full, 1);
      check(!wr_err, "R9", wr_err, 0);
      put(mk_data(), 0);
      @(negedge wr_clk);
      check(wr_err, "R9", wr_err, 1);
      check(exp_q.size() == 256, "R1", exp_q.size(), 256);

      // drain: last part lies inside an open frame, so no insertion (R8)
      @(negedge rd_clk);
      rd_en = 1'b1;
      for (int t = 0; t < 3000 && got_q.size() < 256; t++) @(negedge rd_clk);
      repeat (20) @(negedge rd_clk);
      check(got_q.size() == 256, "R8", got_q.size(), 256);
      for (int i = 0; i < 256 && i < got_q.size(); i++)
         check(got_q[i] == exp_q[i], "R1", got_q[i], exp_q[i]);
      check(rd_empty && rd_part_empty, "R3", {rd_empty, rd_part_empty}, 2'b11);
      check(rd_err && !rd_valid, "R10", {rd_err, rd_valid}, 2'b10);
      check(!wr_full && !wr_part_full, "R2", {wr_full, wr_part_full}, 2'b00);

      // close the frame: read side then inserts idles (R7)
      got_q.delete();
      @(negedge wr_clk);
      begin
         word_t tw;
         tw = mk_term();
         put(tw, 0);
         for (int i = 0; i < 5; i++) put({SLOTS{CODE_IDLE}}, 0);
         repeat (40) @(negedge rd_clk);
         check(got_q.size() > 0 && got_q[0] == tw, "R8", got_q.size() > 0 ? got_q[0] : '0, tw);
      end
      check(got_q.size() > 20, "R7", got_q.size(), 21);
      for (int i = 1; i < got_q.size(); i++)
         check(idle_ref(got_q[i]), "R7", got_q[i], {SLOTS{CODE_IDLE}});
      check(rd_valid && idle_ref(rd_data), "R7", rd_data, {SLOTS{CODE_IDLE}});
      check(rd_err && wr_err, "R10", {rd_err, wr_err}, 2'b11);

      rd_en = 1'b0;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule